// File: doc/BRIEF.md
# Ownership-Handoff Shared Mailbox Aperture

This block is a 256-bit mailbox. It is built as eight 32-bit words and sits between a requester side and a responder side. Each side has its own word-indexed write port and read port. Word index `i` corresponds to byte offset `4*i` in the aperture. Only one side may change the contents at a time. Ownership is kept in a flag that reads back as bit 31 of the last word (index 7). That word also holds the control header.

When the requester writes the last word, the block itself hands ownership to the responder and pulses `req_pending_o`. The responder processes the message, writes its reply, and then writes the last word with bit 31 clear. That returns ownership to the requester and pulses `rsp_ready_o`.

The header field positions inside word 7 are fixed, and the block stores them without interpreting them:
- bits [2:0]: message type
- bits [5:3]: message version
- bit 7: direction (0 = request, 1 = response)
- bits [15:8]: status
- bit 24: function-reset request
- bits 6, [23:16] and [30:25]: reserved

While the requester function is held in its own reset (`func_rst_i`), every requester-side read returns all ones. This lets requester software recognise the reset state while polling.

Top module: `mbox_aperture`

## Requirements
- R1: After `rst_ni` is asserted, all eight words read 0 from both sides, the requester owns the mailbox (`owner_rsp_o` = 0), and both pulse outputs are low.
- R2: While the requester owns the mailbox, a requester write to word index 0..6 stores the full 32-bit value. The next cycle, that value reads back from both ports at the same index.
- R3: A requester write to word 7 while it owns the mailbox does three things. It stores bits [30:0] of the write data. It forces bit 31 of word 7 (the owner flag) to 1, whatever value was written to bit 31. From the next cycle, `owner_rsp_o` reads 1.
- R4: `req_pending_o` is high for exactly one cycle, namely the cycle after the accepted requester write to word 7, and is low at all other times.
- R5: While the responder owns the mailbox, requester writes to any word change no stored value.
- R6: While the requester owns the mailbox, responder writes to any word change no stored value.
- R7: While the responder owns the mailbox, a responder write to word 7 stores all 32 bits, and bit 31 becomes the new owner flag. If bit 31 is 0, ownership returns to the requester and `rsp_ready_o` is high for exactly the next cycle. If bit 31 is 1, the responder keeps ownership and no pulse is raised.
- R8: While `func_rst_i` is 1, every requester-side read returns 32'hFFFF_FFFF. Responder-side reads and the stored contents are unaffected, so the true contents read back on the requester side once `func_rst_i` falls.
- R9: The responder writes words 0..6 only while it owns the mailbox. The values it writes read back on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| func_rst_i | input | 1 | Requester function held in reset; forces requester reads to all ones |
| req_we_i | input | 1 | Requester write strobe |
| req_addr_i | input | 3 | Requester word index |
| req_wdata_i | input | 32 | Requester write data |
| req_rdata_o | output | 32 | Requester read data (combinational on `req_addr_i`) |
| rsp_we_i | input | 1 | Responder write strobe |
| rsp_addr_i | input | 3 | Responder word index |
| rsp_wdata_i | input | 32 | Responder write data |
| rsp_rdata_o | output | 32 | Responder read data (combinational on `rsp_addr_i`) |
| owner_rsp_o | output | 1 | 1 while the responder owns the mailbox |
| req_pending_o | output | 1 | One-cycle pulse: a request has been handed to the responder |
| rsp_ready_o | output | 1 | One-cycle pulse: ownership has returned to the requester |

## Verification
The in-RTL assertions check on every cycle that:
- the handoff sets the owner flag;
- each pulse lasts one cycle and coincides with the matching change of the owner flag;
- the two pulses never overlap;
- storage stays frozen whenever the only write comes from the side that does not own the mailbox.

Only the bench scenarios can show the data-level behaviour:
- the forced owner bit when the requester writes bit 31 as 0;
- the all-ones read-back during function reset, and the true contents reappearing once it ends;
- the responder keeping ownership when it writes bit 31 as 1;
- data flowing correctly in both directions across a full request/response exchange.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W_DEF    = 32;
  localparam int unsigned NUM_WORDS_DEF = 8;
  // Header field positions within the last word
  localparam int unsigned HDR_TYPE_LSB   = 0;
  localparam int unsigned HDR_VER_LSB    = 3;
  localparam int unsigned HDR_DIR_BIT    = 7;
  localparam int unsigned HDR_STAT_LSB   = 8;
  localparam int unsigned HDR_FNRST_BIT  = 24;
  localparam int unsigned HDR_OWNER_BIT  = 31;
endpackage

// File: rtl/mbox_owner.sv
module mbox_owner (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_last_i,
  input  logic rsp_last_i,
  input  logic rsp_own_bit_i,
  output logic owner_rsp_o,
  output logic req_pending_o,
  output logic rsp_ready_o
);
  logic owner_q, pend_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= 1'b0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      pend_q <= req_last_i;
      rdy_q  <= rsp_last_i & ~rsp_own_bit_i;
      if (req_last_i)      owner_q <= 1'b1;
      else if (rsp_last_i) owner_q <= rsp_own_bit_i;
    end
  end

  assign owner_rsp_o   = owner_q;
  assign req_pending_o = pend_q;
  assign rsp_ready_o   = rdy_q;

  a_r4_pend_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q);
  a_r7_rdy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |=> !rdy_q);
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned AW       = $clog2(NUM_WORDS),
  localparam int unsigned FLAT_W   = WORD_W * NUM_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              owner_i,
  output logic [FLAT_W-1:0] words_o
);
  localparam int unsigned LAST = NUM_WORDS - 1;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == LAST) begin : g_hdr
      // Top bit of the header word lives in the owner flag
      logic [WORD_W-2:0] hdr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hdr_q <= '0;
        else if (wr_en_i && wr_addr_i == AW'(i)) hdr_q <= wr_data_i[WORD_W-2:0];
      end
      assign words_o[i*WORD_W +: WORD_W] = {owner_i, hdr_q};
    end else begin : g_data
      logic [WORD_W-1:0] data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) data_q <= '0;
        else if (wr_en_i && wr_addr_i == AW'(i)) data_q <= wr_data_i;
      end
      assign words_o[i*WORD_W +: WORD_W] = data_q;
    end
  end
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8,
  localparam int unsigned AW       = $clog2(NUM_WORDS),
  localparam int unsigned FLAT_W   = WORD_W * NUM_WORDS
) (
  input  logic [FLAT_W-1:0] words_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              force_ones_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (addr_i == AW'(i)) sel = words_i[i*WORD_W +: WORD_W];
  end
  assign rdata_o = force_ones_i ? '1 : sel;
endmodule

// File: rtl/mbox_aperture.sv
module mbox_aperture #(
  parameter int unsigned WORD_W    = mbox_pkg::WORD_W_DEF,
  parameter int unsigned NUM_WORDS = mbox_pkg::NUM_WORDS_DEF,
  localparam int unsigned AW       = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              func_rst_i,
  input  logic              req_we_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic [WORD_W-1:0] req_rdata_o,
  input  logic              rsp_we_i,
  input  logic [AW-1:0]     rsp_addr_i,
  input  logic [WORD_W-1:0] rsp_wdata_i,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              owner_rsp_o,
  output logic              req_pending_o,
  output logic              rsp_ready_o
);
  localparam int unsigned FLAT_W = WORD_W * NUM_WORDS;
  localparam logic [AW-1:0] LAST_A = AW'(NUM_WORDS - 1);

  logic              owner;
  logic              req_acc, rsp_acc, wr_en;
  logic [AW-1:0]     wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [FLAT_W-1:0] words;

  // Only the current owner may write; the two accept terms are exclusive
  assign req_acc = req_we_i & ~owner;
  assign rsp_acc = rsp_we_i &  owner;
  assign wr_en   = req_acc | rsp_acc;
  assign wr_addr = req_acc ? req_addr_i  : rsp_addr_i;
  assign wr_data = req_acc ? req_wdata_i : rsp_wdata_i;

  mbox_owner i_owner (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_last_i    (req_acc && req_addr_i == LAST_A),
    .rsp_last_i    (rsp_acc && rsp_addr_i == LAST_A),
    .rsp_own_bit_i (rsp_wdata_i[WORD_W-1]),
    .owner_rsp_o   (owner),
    .req_pending_o (req_pending_o),
    .rsp_ready_o   (rsp_ready_o)
  );

  mbox_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .owner_i   (owner),
    .words_o   (words)
  );

  mbox_rd_port #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_req_rd (
    .words_i      (words),
    .addr_i       (req_addr_i),
    .force_ones_i (func_rst_i),
    .rdata_o      (req_rdata_o)
  );

  mbox_rd_port #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_rsp_rd (
    .words_i      (words),
    .addr_i       (rsp_addr_i),
    .force_ones_i (1'b0),
    .rdata_o      (rsp_rdata_o)
  );

  assign owner_rsp_o = owner;

  a_r3_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_we_i && !owner && req_addr_i == LAST_A) |=> owner_rsp_o);
  a_r4_pend_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_pending_o |-> (owner_rsp_o && !$past(owner_rsp_o)));
  a_r7_ready_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |-> (!owner_rsp_o && $past(owner_rsp_o)));
  a_r7_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_pending_o, rsp_ready_o}));
  a_r5_req_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner && !rsp_we_i) |=> $stable(words));
  a_r6_rsp_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner && !req_we_i) |=> $stable(words));
endmodule

// File: tb/test_mbox_aperture.sv
`timescale 1ns/1ps
module test_mbox_aperture;
  localparam time T = 20ns;

  logic        clk = 1'b0, rst_ni = 1'b0, func_rst = 1'b0;
  logic        req_we = 1'b0, rsp_we = 1'b0;
  logic [2:0]  req_addr = '0, rsp_addr = '0;
  logic [31:0] req_wdata = '0, rsp_wdata = '0;
  logic [31:0] req_rdata, rsp_rdata;
  logic        owner_rsp, req_pending, rsp_ready;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // Reference model
  int unsigned m_mem [8];
  bit m_own = 0, m_pend = 0, m_rdy = 0;

  always #(T/2) clk = ~clk;

  mbox_aperture i_mbox_aperture (
    .clk_i(clk), .rst_ni(rst_ni), .func_rst_i(func_rst),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_rdata_o(req_rdata),
    .rsp_we_i(rsp_we), .rsp_addr_i(rsp_addr), .rsp_wdata_i(rsp_wdata),
    .rsp_rdata_o(rsp_rdata),
    .owner_rsp_o(owner_rsp), .req_pending_o(req_pending), .rsp_ready_o(rsp_ready)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [31:0] exp_req;
    exp_req = func_rst ? 32'hFFFF_FFFF : m_mem[req_addr];
    check(cur_req, req_rdata, exp_req);
    check(cur_req, rsp_rdata, m_mem[rsp_addr]);
    check("R3", {31'd0, owner_rsp}, {31'd0, m_own});
    check("R4", {31'd0, req_pending}, {31'd0, m_pend});
    check("R7", {31'd0, rsp_ready}, {31'd0, m_rdy});
  endtask

  // Every cycle: model update at the edge, compare at the falling edge
  always @(posedge clk) begin
    bit own_old;
    own_old = m_own;
    m_pend = 0; m_rdy = 0;
    if (!rst_ni) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_own = 0;
    end else if (req_we && !own_old) begin
      if (req_addr == 3'd7) begin
        m_mem[7] = req_wdata | 32'h8000_0000; m_own = 1; m_pend = 1;
      end else m_mem[req_addr] = req_wdata;
    end else if (rsp_we && own_old) begin
      m_mem[rsp_addr] = rsp_wdata;
      if (rsp_addr == 3'd7) begin
        m_own = rsp_wdata[31]; m_rdy = !rsp_wdata[31];
      end
    end
  end

  always @(negedge clk) if (!done) compare_all();

  task automatic cyc(bit rw, logic [2:0] ra, logic [31:0] rd,
                     bit sw, logic [2:0] sa, logic [31:0] sd);
    req_we = rw; req_addr = ra; req_wdata = rd;
    rsp_we = sw; rsp_addr = sa; rsp_wdata = sd;
    @(negedge clk);
    req_we = 0; rsp_we = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(T * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int a = 0; a < 8; a++) cyc(0, 3'(a), 0, 0, 3'(7 - a), 0);

    // R6: responder writes ignored while requester owns
    cur_req = "R6";
    cyc(0, 3'd1, 0, 1, 3'd1, 32'hDEAD_0001);
    cyc(0, 3'd7, 0, 1, 3'd7, 32'h0000_0081);
    cyc(0, 3'd1, 0, 0, 3'd7, 0);

    // R2: requester fills words 0..6
    cur_req = "R2";
    for (int a = 0; a < 7; a++) cyc(1, 3'(a), 32'h1111_1111 * (a + 1) ^ 32'hA5A5_0F0F, 0, 3'(a), 0);
    for (int a = 0; a < 7; a++) cyc(0, 3'(a), 0, 0, 3'(6 - a), 0);

    // R3/R4: request header with bit 31 written as 0
    cur_req = "R3";
    cyc(1, 3'd7, 32'h0100_0029, 0, 3'd7, 0);
    cyc(0, 3'd7, 0, 0, 3'd7, 0);
    cyc(0, 3'd7, 0, 0, 3'd7, 0);

    // R5: requester writes ignored while responder owns
    cur_req = "R5";
    cyc(1, 3'd2, 32'hBAD0_BAD0, 0, 3'd2, 0);
    cyc(1, 3'd7, 32'h0000_0000, 0, 3'd2, 0);
    cyc(0, 3'd2, 0, 0, 3'd7, 0);

    // R9: responder writes reply data
    cur_req = "R9";
    cyc(0, 3'd0, 0, 1, 3'd0, 32'hCAFE_F00D);
    cyc(0, 3'd0, 0, 1, 3'd6, 32'h0000_ABCD);
    cyc(0, 3'd6, 0, 0, 3'd0, 0);

    // R8: function reset read-back, storage untouched
    cur_req = "R8";
    func_rst = 1'b1;
    for (int a = 0; a < 8; a++) cyc(0, 3'(a), 0, 0, 3'(a), 0);
    func_rst = 1'b0;
    for (int a = 0; a < 8; a++) cyc(0, 3'(a), 0, 0, 3'(a), 0);

    // R7: responder keeps ownership, then releases with a response header
    cur_req = "R7";
    cyc(0, 3'd7, 0, 1, 3'd7, 32'h8000_0011);
    cyc(0, 3'd7, 0, 0, 3'd7, 0);
    cyc(0, 3'd7, 0, 1, 3'd7, 32'h0000_0389);
    cyc(0, 3'd7, 0, 0, 3'd7, 0);
    cyc(0, 3'd7, 0, 1, 3'd3, 32'h5555_5555);

    // R2 again: requester owns after the exchange
    cur_req = "R2";
    cyc(1, 3'd3, 32'h0F0F_F0F0, 0, 3'd3, 0);
    cyc(0, 3'd3, 0, 0, 3'd3, 0);

    // R1: asynchronous reset mid-run clears everything
    cur_req = "R1";
    cyc(1, 3'd7, 32'h0000_0002, 0, 3'd0, 0);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int a = 0; a < 8; a++) cyc(0, 3'(a), 0, 0, 3'(a), 0);

    finish_run();
  end
endmodule